// File: doc/BRIEF.md
# Edge-Triggered Interrupt Controller for Digital Input Ports

This block watches a group of 8-line digital input ports and turns selected signal transitions into a single level interrupt for a host processor. Each port carries two byte-wide masks, one selecting the lines whose low-to-high transitions count and one selecting the lines whose high-to-low transitions count. Two global enables in a control register switch each transition direction on or off for all ports at once. A qualifying transition on any line sets a sticky edge flag. A second qualifying transition that arrives while that flag is still set also raises an overflow flag.

The host reaches the block over a simple byte-wide register bus with one address, a write strobe and a read strobe. Read data is registered and appears one cycle after the read strobe. The host programs the masks and the control register. It reads a status byte holding both flags and a summary bit, and acknowledges events by writing a self-clearing clear register. The input lines are asynchronous to the bus clock, so each one passes through a two-flop synchronizer before transitions are detected.

Top module: `edge_watch_irq`

## Requirements
- R1: After a synchronous active-low reset, every mask, the control register and both flags are zero, `irq` is low, and the status byte reads 0x00.
- R2: A read of address 0x00 returns the parameter `ID_VALUE` (default 0xA5). Writes to address 0x00 have no effect on what it returns.
- R3: A low-to-high transition sets the edge flag (status bit 0) only on a line whose bit is set in its port's rising mask, and only when control bit 3 (global rising enable) is set. Otherwise the transition leaves the flag clear.
- R4: A high-to-low transition sets the edge flag only on a line whose bit is set in its port's falling mask, and only when control bit 4 (global falling enable) is set.
- R5: A qualifying transition that arrives while the edge flag is already set sets the overflow flag (status bit 1). A transition that does not qualify does not set it.
- R6: Address 0x01 is write-only, reads as 0x00, and clears flags only on the cycle it is written. Bit 0 clears the edge flag and bit 2 clears the overflow flag; both may be cleared in one write.
- R7: When a qualifying transition occurs in the same cycle as a write that clears the edge flag, the edge flag stays set.
- R8: The control register sits at address 0x03 with bit 0 = edge interrupt enable, bit 1 = overflow interrupt enable and bit 2 = master enable. `irq` and status bit 2 are high exactly when master enable is set and either the edge flag has its enable set or the overflow flag has its enable set.
- R9: Writing 0x00 to the control register drives `irq` low on the next cycle while the flags keep their values.
- R10: A change on an input line sets the edge flag, and `irq` where enabled, on the third rising clock edge after the change. It has no visible effect after the first or second edge.
- R11: Port p has its rising mask at address 0x40 + 0x10·p + 2 and its falling mask at 0x40 + 0x10·p + 3. Both read back as written, and a write to one port leaves the masks of other ports unchanged.
- R12: `rd_data` takes the addressed register's value on the clock edge where `rd_en` is high, and holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | ADDR_W (8) | Register address for reads and writes |
| wr_data | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rd_data | output | 8 | Registered read data |
| port_in | input | NUM_PORTS*LINE_W (16) | Asynchronous input lines, port p in bits [8p+7:8p] |
| irq | output | 1 | Level interrupt to the host |

## Verification
The main stimulus is a table of transition patterns on port 0. Each pattern is paired with a mask and control setting. The table contrasts single lines against many lines toggling at once, and lines inside the mask against lines outside it. It also contrasts the global direction enables on and off, and a raised flag with and without the master or cause enable. Directed sequences then cover the rest. One repeats a transition to produce overflow while a non-qualifying transition does not. Others clear the flags singly and together, and place a clear in the exact cycle a new edge qualifies. Further sequences count the synchronizer latency edge by edge and drive a second port to show its address decoding.

// File: rtl/edw_pkg.sv
// Package: shared register map constants and the control register layout
// for the edge-triggered interrupt controller.
package edw_pkg;

    // Fixed register addresses (host software decodes these).
    localparam int ADDR_ID     = 'h00;
    localparam int ADDR_CLR    = 'h01;
    localparam int ADDR_STATUS = 'h02;
    localparam int ADDR_CTRL   = 'h03;

    // Per-port register window.
    localparam int PORT_BASE   = 'h40;
    localparam int PORT_STRIDE = 'h10;
    localparam int OFF_RISE    = 2;
    localparam int OFF_FALL    = 3;

    // Clear register bit positions.
    localparam int CLR_EDGE_BIT = 0;
    localparam int CLR_OVF_BIT  = 2;

    // Control register: bit 0 edge_ie ... bit 4 fall_en.
    typedef struct packed {
        logic fall_en;
        logic rise_en;
        logic master_en;
        logic ovf_ie;
        logic edge_ie;
    } ctrl_t;

    // Address of a register inside the window of port p.
    function automatic int port_reg_addr(input int p, input int off);
        return PORT_BASE + PORT_STRIDE * p + off;
    endfunction

endpackage

// File: rtl/edw_sync_det.sv
// Module: edw_sync_det
// Brings one port of asynchronous lines into the clock domain with two
// flops, then compares the synchronized sample with the previous one to
// flag per-line rising and falling transitions.
// Assumes: lines are quasi-static relative to clk; reset is synchronous.
module edw_sync_det #(
    parameter int LINE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] din,
    output logic [LINE_W-1:0] rise,
    output logic [LINE_W-1:0] fall
);

    logic [LINE_W-1:0] meta_q;
    logic [LINE_W-1:0] sync_q;
    logic [LINE_W-1:0] prev_q;

    // Two-flop synchronizer followed by a history register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= din;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // Transition detection from current versus previous sample.
    always_comb begin
        rise = sync_q & ~prev_q;
        fall = ~sync_q & prev_q;
    end

endmodule

// File: rtl/edw_qual.sv
// Module: edw_qual
// Qualifies one port's transitions with its per-line masks and the
// global direction enables, and reduces them to one hit bit.
// Assumes: inputs are single-cycle transition pulses.
module edw_qual #(
    parameter int LINE_W = 8
) (
    input  logic [LINE_W-1:0] rise,
    input  logic [LINE_W-1:0] fall,
    input  logic [LINE_W-1:0] rise_mask,
    input  logic [LINE_W-1:0] fall_mask,
    input  logic              rise_en,
    input  logic              fall_en,
    output logic              hit
);

    // A line counts when its direction is enabled both per bit and globally.
    always_comb begin
        hit = (rise_en && |(rise & rise_mask)) ||
              (fall_en && |(fall & fall_mask));
    end

endmodule

// File: rtl/edge_watch_irq.sv
// Module: edge_watch_irq (top)
// Register-mapped controller that turns masked transitions on several
// input ports into sticky edge/overflow flags and one level interrupt.
// Assumes: one bus access per strobe; registers are 8 bits wide;
// LINE_W <= 8; synchronous active-low reset.
module edge_watch_irq #(
    parameter int         NUM_PORTS = 2,
    parameter int         LINE_W    = 8,
    parameter int         ADDR_W    = 8,
    parameter logic [7:0] ID_VALUE  = 8'hA5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [7:0]                  wr_data,
    input  logic                        wr_en,
    input  logic                        rd_en,
    output logic [7:0]                  rd_data,
    input  logic [NUM_PORTS*LINE_W-1:0] port_in,
    output logic                        irq
);
    import edw_pkg::*;

    localparam int CTRL_W = $bits(ctrl_t);

    ctrl_t                 ctrl_q;
    logic                  edge_q;
    logic                  ovf_q;
    logic [LINE_W-1:0]     rmask_q [NUM_PORTS];
    logic [LINE_W-1:0]     fmask_q [NUM_PORTS];
    logic [NUM_PORTS-1:0]  port_hit;
    logic                  hit;
    logic                  wr_ctrl;
    logic                  wr_clr;
    logic                  cause;
    logic [7:0]            rd_mux;

    // Decode of the fixed-address write targets.
    always_comb begin
        wr_ctrl = wr_en && (addr == ADDR_W'(ADDR_CTRL));
        wr_clr  = wr_en && (addr == ADDR_W'(ADDR_CLR));
    end

    // Per-port detection, qualification and mask storage.
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic [LINE_W-1:0] rise;
        logic [LINE_W-1:0] fall;

        edw_sync_det #(.LINE_W(LINE_W)) u_det (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (port_in[p*LINE_W +: LINE_W]),
            .rise (rise),
            .fall (fall)
        );

        edw_qual #(.LINE_W(LINE_W)) u_qual (
            .rise     (rise),
            .fall     (fall),
            .rise_mask(rmask_q[p]),
            .fall_mask(fmask_q[p]),
            .rise_en  (ctrl_q.rise_en),
            .fall_en  (ctrl_q.fall_en),
            .hit      (port_hit[p])
        );

        // Mask registers of this port, written at their window offsets.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rmask_q[p] <= '0;
                fmask_q[p] <= '0;
            end else if (wr_en) begin
                if (addr == ADDR_W'(port_reg_addr(p, OFF_RISE)))
                    rmask_q[p] <= wr_data[LINE_W-1:0];
                if (addr == ADDR_W'(port_reg_addr(p, OFF_FALL)))
                    fmask_q[p] <= wr_data[LINE_W-1:0];
            end
        end
    end

    assign hit = |port_hit;

    // Control register write.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
    end

    // Sticky flags: a new qualifying edge takes priority over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_q <= 1'b0;
            ovf_q  <= 1'b0;
        end else begin
            if (hit)                                 edge_q <= 1'b1;
            else if (wr_clr && wr_data[CLR_EDGE_BIT]) edge_q <= 1'b0;

            if (hit && edge_q)                       ovf_q <= 1'b1;
            else if (wr_clr && wr_data[CLR_OVF_BIT])  ovf_q <= 1'b0;
        end
    end

    // Interrupt summary from flags and their enables.
    always_comb begin
        cause = (edge_q && ctrl_q.edge_ie) || (ovf_q && ctrl_q.ovf_ie);
        irq   = ctrl_q.master_en && cause;
    end

    // Read multiplexer over fixed registers and the port windows.
    always_comb begin
        rd_mux = 8'h00;
        if (addr == ADDR_W'(ADDR_ID))     rd_mux = ID_VALUE;
        if (addr == ADDR_W'(ADDR_STATUS)) rd_mux = {5'b0, irq, ovf_q, edge_q};
        if (addr == ADDR_W'(ADDR_CTRL))   rd_mux = 8'(ctrl_q);
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (addr == ADDR_W'(port_reg_addr(p, OFF_RISE))) rd_mux = 8'(rmask_q[p]);
            if (addr == ADDR_W'(port_reg_addr(p, OFF_FALL))) rd_mux = 8'(fmask_q[p]);
        end
    end

    // Registered read data, updated only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= 8'h00;
        else if (rd_en) rd_data <= rd_mux;
    end

endmodule

// File: rtl/edw_checker.sv
// Module: edw_checker
// Temporal checks on the controller, attached to every instance of the
// top module by the bind below. Observes ports and internal flags only.
module edw_checker #(
    parameter int         ADDR_W   = 8,
    parameter logic [7:0] ID_VALUE = 8'hA5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        wr_data,
    input logic              wr_en,
    input logic              rd_en,
    input logic [7:0]        rd_data,
    input logic              irq,
    input logic [4:0]        ctrl,
    input logic              edge_flag,
    input logic              ovf_flag,
    input logic              hit
);

    // R8: the interrupt never fires without the master enable.
    a_r8_irq_needs_master: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ctrl[2]);

    // R8: the interrupt never fires without a pending flag.
    a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (edge_flag || ovf_flag));

    // R5: overflow only rises while an edge was already pending.
    a_r5_ovf_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> $past(edge_flag));

    // R6: a clear of the edge flag with no new edge empties it.
    a_r6_edge_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(1) && wr_data[0] && !hit) |=> !edge_flag);

    // R7: a qualifying edge always leaves the edge flag set.
    a_r7_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> edge_flag);

    // R9: writing zero to control silences the interrupt.
    a_r9_ctrl_zero_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(3) && wr_data == 8'h00) |=> !irq);

    // R2: the identification register reads its fixed value.
    a_r2_id_value: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(0)) |=> rd_data == ID_VALUE);

    // R12: read data holds while no read strobe is given.
    a_r12_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

endmodule

bind edge_watch_irq edw_checker #(
    .ADDR_W  (ADDR_W),
    .ID_VALUE(ID_VALUE)
) u_edw_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .wr_data  (wr_data),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .rd_data  (rd_data),
    .irq      (irq),
    .ctrl     (ctrl_q),
    .edge_flag(edge_q),
    .ovf_flag (ovf_q),
    .hit      (hit)
);

// File: tb/edge_watch_irq_bench.sv
// Bench: table-driven transition patterns on port 0, then directed tests.
module edge_watch_irq_bench;

    localparam real CLK_NS = 8.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic [7:0]  wr_data = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_data;
    logic [15:0] port_in = '0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    edge_watch_irq u_edge_watch_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (addr),
        .wr_data(wr_data),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .rd_data(rd_data),
        .port_in(port_in),
        .irq    (irq)
    );

    always #(CLK_NS / 2) clk = ~clk;

    // Entries: {rise_mask, fall_mask, ctrl, start, end, expected status}
    localparam logic [47:0] VEC [8] = '{
        {8'h01, 8'h00, 8'h0D, 8'h00, 8'h01, 8'h05}, // R3 single line rise
        {8'h01, 8'h00, 8'h0D, 8'h01, 8'h00, 8'h00}, // R4 fall with no fall mask
        {8'h00, 8'h80, 8'h15, 8'h80, 8'h00, 8'h05}, // R4 single line fall
        {8'hFF, 8'h00, 8'h05, 8'h00, 8'hFF, 8'h00}, // R3 global rise off
        {8'hF0, 8'h00, 8'h0D, 8'h00, 8'h0F, 8'h00}, // R3 lines outside mask
        {8'hF0, 8'h00, 8'h09, 8'h00, 8'h10, 8'h01}, // R8 no master enable
        {8'h01, 8'h01, 8'h1C, 8'h01, 8'h00, 8'h01}, // R8 no edge enable
        {8'h00, 8'hFF, 8'h1D, 8'hAA, 8'h55, 8'h05}  // R4 mixed directions
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [7:0] d);
        addr = a; rd_en = 1'b1;
        @(posedge clk); @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] rv;
        settle(3);
        rst_n = 1'b1;
        settle(1);

        // R1: reset state
        check("R1 irq", {7'b0, irq}, 8'h00);
        bus_rd(8'h02, rv); check("R1 status", rv, 8'h00);
        bus_rd(8'h03, rv); check("R1 ctrl", rv, 8'h00);
        bus_rd(8'h42, rv); check("R1 rise mask", rv, 8'h00);
        bus_rd(8'h53, rv); check("R1 fall mask", rv, 8'h00);

        // R2: identification register, write ignored
        bus_rd(8'h00, rv); check("R2 id", rv, 8'hA5);
        bus_wr(8'h00, 8'h3C);
        bus_rd(8'h00, rv); check("R2 id after write", rv, 8'hA5);

        // R12: read data holds without strobe
        addr = 8'h03; settle(3);
        check("R12 hold", rd_data, 8'hA5);

        // Table walk on port 0
        for (int i = 0; i < 8; i++) begin
            bus_wr(8'h42, VEC[i][47:40]);
            bus_wr(8'h43, VEC[i][39:32]);
            bus_wr(8'h03, VEC[i][31:24]);
            port_in[7:0] = VEC[i][23:16];
            settle(5);
            bus_wr(8'h01, 8'h05);
            port_in[7:0] = VEC[i][15:8];
            settle(5);
            bus_rd(8'h02, rv);
            check($sformatf("R3/R4/R8 vector %0d status", i), rv, VEC[i][7:0]);
            check($sformatf("R8 vector %0d irq", i), {7'b0, irq}, {7'b0, VEC[i][2]});
            bus_wr(8'h03, 8'h00);
            bus_wr(8'h01, 8'h05);
        end

        // R10: synchronizer latency, counted edge by edge
        port_in[7:0] = 8'h00;
        bus_wr(8'h42, 8'h01); bus_wr(8'h43, 8'h00); bus_wr(8'h03, 8'h0D);
        settle(5); bus_wr(8'h01, 8'h05);
        port_in[0] = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R10 after edge 1", {7'b0, irq}, 8'h00);
        @(posedge clk); @(negedge clk);
        check("R10 after edge 2", {7'b0, irq}, 8'h00);
        @(posedge clk); @(negedge clk);
        check("R10 after edge 3", {7'b0, irq}, 8'h01);

        // R5: non-qualifying fall gives no overflow, a second rise does
        bus_wr(8'h03, 8'h0F);
        port_in[0] = 1'b0; settle(5);
        bus_rd(8'h02, rv); check("R5 no overflow on masked fall", rv, 8'h05);
        port_in[0] = 1'b1; settle(5);
        bus_rd(8'h02, rv); check("R5 overflow set", rv, 8'h07);

        // R8: overflow cause alone drives irq
        bus_wr(8'h03, 8'h06);
        check("R8 overflow irq", {7'b0, irq}, 8'h01);

        // R6: separate and combined clears, write-only clear register
        bus_wr(8'h01, 8'h04);
        bus_rd(8'h02, rv); check("R6 clear overflow only", rv, 8'h01);
        bus_wr(8'h01, 8'h01);
        bus_rd(8'h02, rv); check("R6 clear edge", rv, 8'h00);
        bus_wr(8'h03, 8'h0F);
        port_in[0] = 1'b0; settle(2); bus_wr(8'h01, 8'h05);
        port_in[0] = 1'b1; settle(5);
        port_in[0] = 1'b0; settle(2);
        port_in[0] = 1'b1; settle(5);
        bus_rd(8'h02, rv); check("R6 both set before clear", rv, 8'h07);
        bus_wr(8'h01, 8'h05);
        bus_rd(8'h02, rv); check("R6 combined clear", rv, 8'h00);
        bus_rd(8'h01, rv); check("R6 clear reads zero", rv, 8'h00);

        // R9: control write of zero silences irq, flag kept
        port_in[0] = 1'b0; settle(2);
        port_in[0] = 1'b1; settle(5);
        check("R9 irq before", {7'b0, irq}, 8'h01);
        bus_wr(8'h03, 8'h00);
        check("R9 irq after zero", {7'b0, irq}, 8'h00);
        bus_rd(8'h02, rv); check("R9 flag kept", rv, 8'h01);

        // R7: clear in the same cycle as a qualifying edge
        bus_wr(8'h03, 8'h0D);
        port_in[0] = 1'b0; settle(5);
        port_in[0] = 1'b1;
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        addr = 8'h01; wr_data = 8'h01; wr_en = 1'b1;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
        bus_rd(8'h02, rv); check("R7 edge wins over clear", rv, 8'h07);
        bus_wr(8'h01, 8'h05);

        // R11: second port window decoding and independence
        bus_wr(8'h52, 8'h3C);
        bus_wr(8'h53, 8'hC3);
        bus_rd(8'h52, rv); check("R11 port1 rise mask", rv, 8'h3C);
        bus_rd(8'h53, rv); check("R11 port1 fall mask", rv, 8'hC3);
        bus_rd(8'h42, rv); check("R11 port0 unchanged", rv, 8'h01);
        bus_wr(8'h42, 8'h00);
        port_in[15:8] = 8'h01; settle(5);
        bus_rd(8'h02, rv); check("R11 port1 unmasked line", rv, 8'h00);
        port_in[15:8] = 8'h05; settle(5);
        bus_rd(8'h02, rv); check("R11 port1 masked line", rv, 8'h05);

        // R1: reset from a busy state
        rst_n = 1'b0; settle(2); rst_n = 1'b1; settle(1);
        check("R1 irq after reset", {7'b0, irq}, 8'h00);
        bus_rd(8'h02, rv); check("R1 status after reset", rv, 8'h00);
        bus_rd(8'h52, rv); check("R1 mask after reset", rv, 8'h00);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule